// File: doc/BRIEF.md
# Locality Command-Response Engine

This block is the per-locality command and response engine behind a FIFO-style register window of a trusted security module. Host software writes a command one byte at a time into a shared byte buffer. The block reads the big-endian length carried in the command header to decide when the command is complete. When host software then sets the go flag, the block hands the buffer to an execution backend through a start pulse. The backend writes its response into the same buffer and signals completion. After that, host reads drain the response byte by byte.

The block has five states: idle, ready, receiving, executing and response-available. It owns the 32-bit status word that host software polls. Every status update rewrites the flag byte, with two exceptions: the self-test-done flag, which is sticky, and the two-bit family code, which is captured during reset. Arbitration between localities, interrupt routing and command execution belong to neighbouring blocks. This block only emits one-cycle event pulses and request pulses for them.

Top module: `locality_cmd_engine`

## Requirements
- R1: While `rst_n` is low, the family code is taken from `fam_v2` (0 for the 1.2 family, 1 for the 2.0 family). After reset, `sts_rdata` equals the family code at bits 27:26 with every other bit zero, and `fifo_rdata` reads 0xFF.
- R2: Flag positions in `sts_rdata[7:0]` are: valid bit 7, command-ready bit 6, go bit 5, data-available bit 4, expect bit 3, self-test-done bit 2 and response-retry bit 1. Bits 23:8 hold the burst count. Writing command-ready does the following by state:
  - In idle, the state moves to ready, the flags become command-ready alone and `ev_cmd_ready` pulses.
  - In receiving or response-available, the state returns to ready in the same way, with the pulse only if command-ready was clear.
  - In executing, the write is ignored.
- R3: The first FIFO byte written in ready moves the state to receiving and sets expect and valid. While expect is set, the burst count is the number of free buffer bytes.
- R4: After each stored byte, expect stays set while fewer than 6 bytes have arrived, or while the header length is greater than the byte count. The header length is the big-endian 32-bit value in bytes 2 to 5, with byte 2 most significant. Otherwise only valid remains set.
- R5: A byte written while expect is set and the buffer holds DEPTH bytes is dropped, and the flags become valid alone. Bytes written while expect is clear, in executing or in response-available are dropped and leave the buffer unchanged.
- R6: Writing go in receiving with expect clear moves the state to executing. It pulses `cmd_start` with `cmd_len` equal to the byte count, and clears all non-sticky flags.
- R7: `be_done` in executing moves the state to response-available and sets valid and data-available. The burst count becomes the response length.
- R8: In response-available, reads return the buffer bytes in order. Reading the last byte leaves valid alone and pulses `ev_sts_valid`. Later reads return 0xFF.
- R9: Writing response-retry in response-available rewinds reading to byte 0 and restores valid and data-available.
- R10: Outside response-available, `fifo_rdata` is 0xFF.
- R11: Self-test-done, once set by `be_selftest` together with `be_done`, stays set until reset. The family field never changes outside reset.
- R12: With the 2.0 family, a status write with bit 24 in executing pulses `cancel_req`. A status write with bit 25 from locality 3 or 4 pulses `est_rst_req`. With the 1.2 family, neither request ever pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fam_v2 | input | 1 | Family select, captured while in reset |
| locality | input | 3 | Locality of the current host access |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status write data |
| sts_rdata | output | 32 | Status word: family, burst count, flags |
| fifo_wr | input | 1 | FIFO byte write strobe |
| fifo_wdata | input | 8 | FIFO write byte |
| fifo_rd | input | 1 | FIFO byte read strobe (consumes the byte) |
| fifo_rdata | output | 8 | Current FIFO read byte |
| cmd_start | output | 1 | Pulse: command handed to backend |
| cmd_len | output | CW | Command byte count |
| be_addr | input | AW | Backend buffer address |
| be_we | input | 1 | Backend buffer write enable (executing only) |
| be_wdata | input | 8 | Backend buffer write byte |
| be_rdata | output | 8 | Buffer byte at `be_addr` |
| be_done | input | 1 | Backend response ready |
| be_rsp_len | input | CW | Response length in bytes |
| be_selftest | input | 1 | Self-test completed, qualified by `be_done` |
| cancel_req | output | 1 | Pulse: cancel request to backend |
| est_rst_req | output | 1 | Pulse: establishment reset request |
| ev_cmd_ready | output | 1 | Pulse: command-ready event |
| ev_sts_valid | output | 1 | Pulse: status-valid event |

## Verification
Every host or backend strobe takes effect at the single clock edge that samples it. The status word, the event pulses, the request pulses and the read byte therefore all show the result one edge after the strobe. The bench drives each strobe for one cycle from a falling edge and samples on the next falling edge, after exactly that one registering edge. At that point the pulse outputs are still high and `fifo_rdata` already shows the next byte. Read data is sampled before the strobe's edge, because the read port is combinational from the read offset.

// File: rtl/locality_cmd_engine.sv
module locality_cmd_engine #(
  parameter int DEPTH = 16,
  parameter int AW = $clog2(DEPTH),
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fam_v2,
  input  logic [2:0]    locality,
  input  logic          sts_wr,
  input  logic [31:0]   sts_wdata,
  output logic [31:0]   sts_rdata,
  input  logic          fifo_wr,
  input  logic [7:0]    fifo_wdata,
  input  logic          fifo_rd,
  output logic [7:0]    fifo_rdata,
  output logic          cmd_start,
  output logic [CW-1:0] cmd_len,
  input  logic [AW-1:0] be_addr,
  input  logic          be_we,
  input  logic [7:0]    be_wdata,
  output logic [7:0]    be_rdata,
  input  logic          be_done,
  input  logic [CW-1:0] be_rsp_len,
  input  logic          be_selftest,
  output logic          cancel_req,
  output logic          est_rst_req,
  output logic          ev_cmd_ready,
  output logic          ev_sts_valid
);
  localparam logic [7:0] F_VALID = 8'h80;
  localparam logic [7:0] F_CRDY  = 8'h40;
  localparam logic [7:0] F_DAV   = 8'h10;
  localparam logic [7:0] F_EXP   = 8'h08;
  localparam logic [CW-1:0] HDR_BYTES = CW'(6);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_READY, S_RECV, S_EXEC, S_DONE} state_t;

  state_t          state;
  logic [7:0]      flags;
  logic [1:0]      family;
  logic [CW-1:0]   w_cnt, r_cnt, rsp_len;
  logic [31:0]     hdr_len;
  logic [7:0]      mem [DEPTH];

  wire [7:0]    keep    = flags & 8'h04;
  wire          read_ok = (state == S_DONE) && (r_cnt < rsp_len);
  wire          taking  = (state == S_READY) || (state == S_RECV && flags[3]);
  wire          space   = w_cnt < FULL;
  wire [CW-1:0] cnt_n   = w_cnt + 1'b1;
  wire [31:0]   len_n   = (w_cnt >= CW'(2) && w_cnt <= CW'(5)) ?
                          {hdr_len[23:0], fifo_wdata} : hdr_len;
  wire          done_n  = (cnt_n >= HDR_BYTES) && (len_n <= 32'(cnt_n));
  wire          be_fin  = be_done && state == S_EXEC;
  wire          host_st = !be_fin && !sts_wr && fifo_wr && taking && space;

  logic [15:0] burst;
  always_comb begin
    if (state == S_RECV && flags[3]) burst = 16'(FULL - w_cnt);
    else if (read_ok)                burst = 16'(rsp_len - r_cnt);
    else                             burst = '0;
  end

  assign sts_rdata  = {4'b0, family, 2'b0, burst, flags};
  assign fifo_rdata = read_ok ? mem[r_cnt[AW-1:0]] : 8'hFF;
  assign be_rdata   = mem[be_addr];
  assign cmd_len    = w_cnt;

  always_ff @(posedge clk) begin
    if (state == S_EXEC && be_we) mem[be_addr] <= be_wdata;
    else if (host_st)             mem[w_cnt[AW-1:0]] <= fifo_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      flags <= '0;
      family <= {1'b0, fam_v2};
      w_cnt <= '0;
      r_cnt <= '0;
      rsp_len <= '0;
      hdr_len <= '0;
      cmd_start <= 1'b0;
      cancel_req <= 1'b0;
      est_rst_req <= 1'b0;
      ev_cmd_ready <= 1'b0;
      ev_sts_valid <= 1'b0;
    end else begin
      cmd_start <= 1'b0;
      cancel_req <= 1'b0;
      est_rst_req <= 1'b0;
      ev_cmd_ready <= 1'b0;
      ev_sts_valid <= 1'b0;
      if (be_fin) begin
        state <= S_DONE;
        flags <= F_VALID | F_DAV | keep | {5'b0, be_selftest, 2'b0};
        r_cnt <= '0;
        w_cnt <= '0;
        rsp_len <= (be_rsp_len > FULL) ? FULL : be_rsp_len;
      end else if (sts_wr) begin
        if (family == 2'd1) begin
          if (sts_wdata[24] && state == S_EXEC) cancel_req <= 1'b1;
          if (sts_wdata[25] && (locality == 3'd3 || locality == 3'd4)) est_rst_req <= 1'b1;
        end
        if (sts_wdata[6]) begin
          if (state == S_IDLE || state == S_RECV || state == S_DONE) begin
            state <= S_READY;
            flags <= keep | F_CRDY;
            w_cnt <= '0;
            r_cnt <= '0;
            ev_cmd_ready <= !flags[6];
          end
        end else if (sts_wdata[5]) begin
          if (state == S_RECV && !flags[3]) begin
            state <= S_EXEC;
            flags <= keep;
            cmd_start <= 1'b1;
          end
        end else if (sts_wdata[1]) begin
          if (state == S_DONE) begin
            r_cnt <= '0;
            flags <= keep | F_VALID | F_DAV;
          end
        end
      end else if (fifo_wr && taking) begin
        state <= S_RECV;
        if (space) begin
          w_cnt <= cnt_n;
          hdr_len <= len_n;
          flags <= keep | F_VALID | (done_n ? 8'h00 : F_EXP);
        end else begin
          flags <= keep | F_VALID;
        end
      end else if (fifo_rd && read_ok) begin
        r_cnt <= r_cnt + 1'b1;
        if (r_cnt + 1'b1 == rsp_len) begin
          flags <= keep | F_VALID;
          ev_sts_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/locality_cmd_engine_chk.sv
module locality_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  locality,
  input logic [31:0] sts_rdata,
  input logic        cmd_start,
  input logic        cancel_req,
  input logic        est_rst_req,
  input logic        ev_cmd_ready,
  input logic        ev_sts_valid
);
  // R2
  cmd_ready_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_ready |-> (sts_rdata[7:0] & 8'hFB) == 8'h40);
  // R4
  expect_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rdata[3] |-> sts_rdata[7]);
  // R6
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> (sts_rdata[7:0] & 8'hFB) == 8'h00);
  // R8
  last_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sts_valid |-> (sts_rdata[7:0] & 8'hFB) == 8'h80);
  // R11
  selftest_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rdata[2] |=> sts_rdata[2]);
  // R11
  family_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(sts_rdata[27:26]));
  // R12
  cancel_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_req |-> sts_rdata[27:26] == 2'd1);
  // R12
  est_locality_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_rst_req |-> (sts_rdata[27:26] == 2'd1) &&
                    ($past(locality) == 3'd3 || $past(locality) == 3'd4));
endmodule

bind locality_cmd_engine locality_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .locality(locality), .sts_rdata(sts_rdata),
  .cmd_start(cmd_start), .cancel_req(cancel_req), .est_rst_req(est_rst_req),
  .ev_cmd_ready(ev_cmd_ready), .ev_sts_valid(ev_sts_valid)
);

// File: tb/test_locality_cmd_engine.sv
module test_locality_cmd_engine;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, fam_v2 = 0;
  logic [2:0] locality = 0;
  logic sts_wr = 0, fifo_wr = 0, fifo_rd = 0, be_we = 0, be_done = 0, be_selftest = 0;
  logic [31:0] sts_wdata = 0;
  logic [7:0] fifo_wdata = 0, be_wdata = 0;
  logic [AW-1:0] be_addr = 0;
  logic [CW-1:0] be_rsp_len = 0;
  logic [31:0] sts_rdata;
  logic [7:0] fifo_rdata, be_rdata;
  logic cmd_start, cancel_req, est_rst_req, ev_cmd_ready, ev_sts_valid;
  logic [CW-1:0] cmd_len;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  locality_cmd_engine #(.DEPTH(DEPTH)) i_locality_cmd_engine (
    .clk(clk), .rst_n(rst_n), .fam_v2(fam_v2), .locality(locality),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
    .cmd_start(cmd_start), .cmd_len(cmd_len), .be_addr(be_addr), .be_we(be_we),
    .be_wdata(be_wdata), .be_rdata(be_rdata), .be_done(be_done), .be_rsp_len(be_rsp_len),
    .be_selftest(be_selftest), .cancel_req(cancel_req), .est_rst_req(est_rst_req),
    .ev_cmd_ready(ev_cmd_ready), .ev_sts_valid(ev_sts_valid));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic sts_write(input logic [31:0] v);
    @(negedge clk); sts_wr = 1; sts_wdata = v;
    @(negedge clk); sts_wr = 0; sts_wdata = 0;
  endtask

  task automatic byte_write(input logic [7:0] b);
    @(negedge clk); fifo_wr = 1; fifo_wdata = b;
    @(negedge clk); fifo_wr = 0;
  endtask

  task automatic byte_read(output logic [7:0] b);
    @(negedge clk); b = fifo_rdata; fifo_rd = 1;
    @(negedge clk); fifo_rd = 0;
  endtask

  task automatic do_reset(input logic fam);
    @(negedge clk); rst_n = 0; fam_v2 = fam;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  function automatic logic [7:0] cmd_byte(input int i, input int len);
    if (i >= 2 && i <= 5) return 8'((len >> (8 * (5 - i))) & 255);
    return 8'(i * 7 + len);
  endfunction

  function automatic logic [31:0] sword(input logic [1:0] fam, input int burst, input logic [7:0] f);
    return {4'b0, fam, 2'b0, 16'(burst), f};
  endfunction

  initial begin
    logic [7:0] b;
    logic [7:0] st;
    for (int fam = 0; fam < 2; fam++) begin
      st = 8'h00;
      do_reset(fam[0]);
      // R1
      chk(sts_rdata == sword(2'(fam), 0, 0), "R1", sts_rdata, sword(2'(fam), 0, 0));
      chk(fifo_rdata == 8'hFF, "R1", {24'b0, fifo_rdata}, 32'hFF);
      // R10: read in idle
      byte_read(b);
      chk(b == 8'hFF, "R10", {24'b0, b}, 32'hFF);
      // R2
      sts_write(32'h40);
      chk(sts_rdata == sword(2'(fam), 0, 8'h40), "R2", sts_rdata, sword(2'(fam), 0, 8'h40));
      chk(ev_cmd_ready == 1'b1, "R2", {31'b0, ev_cmd_ready}, 1);
      sts_write(32'h40);
      chk(ev_cmd_ready == 1'b0, "R2", {31'b0, ev_cmd_ready}, 0);
      for (int len = 6; len <= DEPTH; len++) begin
        for (int k = 1; k <= len; k++) begin
          logic exp_e;
          byte_write(cmd_byte(k - 1, len));
          exp_e = !(k >= 6 && len <= k);
          // R3 R4
          chk(sts_rdata == sword(2'(fam), exp_e ? DEPTH - k : 0, 8'h80 | (exp_e ? 8'h08 : 8'h00) | st),
              k == 1 ? "R3" : "R4", sts_rdata,
              sword(2'(fam), exp_e ? DEPTH - k : 0, 8'h80 | (exp_e ? 8'h08 : 8'h00) | st));
        end
        // R10: read while receiving
        byte_read(b);
        chk(b == 8'hFF, "R10", {24'b0, b}, 32'hFF);
        // R5: extra byte after completion is dropped
        byte_write(8'hA5);
        chk(sts_rdata == sword(2'(fam), 0, 8'h80 | st), "R5", sts_rdata, sword(2'(fam), 0, 8'h80 | st));
        // R6
        sts_write(32'h20);
        chk(cmd_start == 1'b1 && cmd_len == CW'(len), "R6", {cmd_start, 26'b0, cmd_len}, {1'b1, 26'b0, 5'(len)});
        chk(sts_rdata == sword(2'(fam), 0, st), "R6", sts_rdata, sword(2'(fam), 0, st));
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
          be_addr = AW'(i); #1;
          chk(be_rdata == cmd_byte(i, len), "R4", {24'b0, be_rdata}, {24'b0, cmd_byte(i, len)});
        end
        for (int i = 0; i < len - 3; i++) begin
          @(negedge clk); be_we = 1; be_addr = AW'(i); be_wdata = ~cmd_byte(i, len);
        end
        @(negedge clk); be_we = 0;
        be_done = 1; be_rsp_len = CW'(len - 3); be_selftest = (len == 10);
        @(negedge clk); be_done = 0; be_selftest = 0;
        if (len == 10) st = 8'h04;
        // R7 R11
        chk(sts_rdata == sword(2'(fam), len - 3, 8'h90 | st), "R7", sts_rdata, sword(2'(fam), len - 3, 8'h90 | st));
        for (int i = 0; i < len - 3; i++) begin
          byte_read(b);
          // R8
          chk(b == ~cmd_byte(i, len), "R8", {24'b0, b}, {24'b0, ~cmd_byte(i, len)});
        end
        chk(ev_sts_valid == 1'b1 && sts_rdata == sword(2'(fam), 0, 8'h80 | st), "R8",
            {ev_sts_valid, sts_rdata[30:0]}, {1'b1, sword(2'(fam), 0, 8'h80 | st)});
        byte_read(b);
        chk(b == 8'hFF, "R8", {24'b0, b}, 32'hFF);
        // R9
        sts_write(32'h02);
        chk(sts_rdata == sword(2'(fam), len - 3, 8'h90 | st), "R9", sts_rdata, sword(2'(fam), len - 3, 8'h90 | st));
        byte_read(b);
        chk(b == ~cmd_byte(0, len), "R9", {24'b0, b}, {24'b0, ~cmd_byte(0, len)});
        // R2: back to ready from completion, R11 sticky kept
        sts_write(32'h40);
        chk(ev_cmd_ready == 1'b1 && sts_rdata == sword(2'(fam), 0, 8'h40 | st), "R11",
            {ev_cmd_ready, sts_rdata[30:0]}, {1'b1, sword(2'(fam), 0, 8'h40 | st)});
      end
      // R5: overflow with header length beyond buffer
      for (int k = 1; k <= DEPTH; k++) byte_write(cmd_byte(k - 1, 100));
      chk(sts_rdata[7:0] == (8'h88 | st), "R5", sts_rdata, 32'h88 | st);
      byte_write(8'h3C);
      chk(sts_rdata == sword(2'(fam), 0, 8'h80 | st), "R5", sts_rdata, sword(2'(fam), 0, 8'h80 | st));
      sts_write(32'h20);
      // R5: byte in executing is dropped
      byte_write(8'h11);
      @(negedge clk); be_addr = 0; #1;
      chk(be_rdata == cmd_byte(0, 100), "R5", {24'b0, be_rdata}, {24'b0, cmd_byte(0, 100)});
      // R2: command-ready ignored in executing
      sts_write(32'h40);
      chk(sts_rdata == sword(2'(fam), 0, st) && !ev_cmd_ready, "R2", sts_rdata, sword(2'(fam), 0, st));
      // R12
      sts_write(32'h0100_0000);
      chk(cancel_req == fam[0], "R12", {31'b0, cancel_req}, fam);
      locality = 3'd3;
      sts_write(32'h0200_0000);
      chk(est_rst_req == fam[0], "R12", {31'b0, est_rst_req}, fam);
      locality = 3'd4;
      sts_write(32'h0200_0000);
      chk(est_rst_req == fam[0], "R12", {31'b0, est_rst_req}, fam);
      locality = 3'd2;
      sts_write(32'h0200_0000);
      chk(est_rst_req == 1'b0, "R12", {31'b0, est_rst_req}, 0);
      locality = 3'd0;
      // R11: family unchanged
      chk(sts_rdata[27:26] == 2'(fam), "R11", {30'b0, sts_rdata[27:26]}, fam);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule